// File: doc/BRIEF.md
# External Data Memory Access Controller

This block runs the bus side of a microcontroller's external data memory transfers. The CPU presents one read or write request and waits for a one-cycle completion pulse. The block drives a 24-bit address, separate output and input data buses, a tri-state control for the output bus, and read and write strobes.

The address can be built in two ways. In pointer mode, a 16-bit data pointer gives the low bits and an 8-bit page value gives the top byte. In indirect mode, an 8-bit register offset gives the low bits and a 16-bit high-address value gives the rest. Software sets the strobe width through a 3-bit stretch field, giving 1 to 8 clocks. A slow memory can extend any access by holding its ready input low.

Top module: `xmem_access_ctrl`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr` and `done` are low and `mem_dz` is high.
- R2: With `req_mode` = 0 (pointer mode), the address driven during the strobe is `{page, dptr}`, with the page in bits 23:16.
- R3: With `req_mode` = 1 (indirect mode), the address driven during the strobe is `{hi_addr, ofs}`, with the offset in bits 7:0.
- R4: A request accepted at a clock edge starts the strobe in the next cycle. With `mem_rdy` high, the strobe lasts `stretch`+1 cycles (encoding 0..7 gives 1..8 clocks).
- R5: The strobe ends only in a cycle where `mem_rdy` is high and at least `stretch`+1 strobe cycles have passed. If ready is low for the first D strobe cycles, the strobe lasts max(`stretch`+1, D+1) cycles.
- R6: `done` is high for exactly one cycle, the cycle right after the last strobe cycle. For a read, `rdata` then holds the `mem_din` value sampled in the last strobe cycle.
- R7: During a write strobe, `mem_dz` is low and `mem_dout` equals the `wdata` captured at acceptance. During a read strobe and when idle, `mem_dz` is high.
- R8: `mem_addr` and `mem_dout` keep their values for every cycle of the strobe, including wait cycles, even if the request inputs change.
- R9: A request raised while an access is in progress, up to and including the done cycle, is ignored: it starts no later access and does not alter the current one.
- R10: `req_wr` = 1 selects `mem_wr`, and `req_wr` = 0 selects `mem_rd`. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request from the CPU |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mode | input | 1 | 0 = pointer plus page, 1 = offset plus high address |
| stretch | input | 3 | Strobe width code, width = code + 1 clocks |
| dptr | input | 16 | Data pointer (pointer mode, low 16 bits) |
| page | input | 8 | Page byte (pointer mode, bits 23:16) |
| hi_addr | input | 16 | High address (indirect mode, bits 23:8) |
| ofs | input | 8 | Register offset (indirect mode, bits 7:0) |
| wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| mem_addr | output | 24 | Memory address bus |
| mem_dout | output | 8 | Data bus to memory |
| mem_din | input | 8 | Data bus from memory |
| mem_dz | output | 1 | High = output data bus released |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdy | input | 1 | Memory ready, low inserts waits |

## Verification
The hardest case to reach is the interplay between the programmed width and ready held low. Waits must extend only the cycles after the programmed count runs out, never add to it. The bench's memory model drops ready for a chosen number of leading strobe cycles, and the sweep covers every stretch code against delays both shorter and longer than the width. A second hard case is a request that lands mid-access or in the done cycle. Some sweep points raise such a request with new address and data inputs. The bench then checks that the outputs stay unchanged and that no extra strobe follows.

// File: rtl/xmem_pkg.sv
// Package: shared state type for the external data memory access controller.
// Assumes: nothing beyond a three-phase access (idle, strobe, completion).
package xmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2
    } xacc_state_e;
endpackage

// File: rtl/xmem_addr_gen.sv
// Module: forms the wide external address from one of two sources.
// Assumes: mode 0 = {page, pointer}, mode 1 = {high address, offset};
// the result is purely combinational and registered by the caller.
module xmem_addr_gen #(
    parameter int PTR_W  = 16,
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8,
    localparam int ADDR_W = PTR_W + PAGE_W,
    localparam int HI_W   = ADDR_W - OFS_W
) (
    input  logic              mode,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PAGE_W-1:0] page,
    input  logic [HI_W-1:0]   hi,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);
    // Select the address source by mode.
    always_comb begin
        if (mode) addr = {hi, ofs};
        else      addr = {page, ptr};
    end
endmodule

// File: rtl/xmem_strobe_seq.sv
// Module: access sequencer; counts the programmed strobe width and then
// holds the strobe until ready, then gives one completion cycle.
// Assumes: requests are taken only in idle; stretch is sampled at acceptance.
module xmem_strobe_seq
    import xmem_pkg::*;
#(
    parameter int STR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [STR_W-1:0] stretch,
    input  logic             rdy,
    output logic             accept,
    output logic             active,
    output logic             last,
    output logic             done
);
    localparam int HELD_W = STR_W + 1;

    xacc_state_e      state;
    logic [STR_W-1:0] cnt;

    // Main sequence: idle -> strobe (count down, then wait for ready) -> done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    state <= ST_STROBE;
                    cnt   <= stretch;
                end
                ST_STROBE: begin
                    if (cnt != '0)  cnt   <= cnt - 1'b1;
                    else if (rdy)   state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign accept = (state == ST_IDLE) && req;
    assign active = (state == ST_STROBE);
    assign last   = active && (cnt == '0) && rdy;
    assign done   = (state == ST_DONE);

    // Checker-side bookkeeping: strobe cycles elapsed and programmed width.
    logic [HELD_W-1:0] held;
    logic [STR_W-1:0]  str_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= '0;
            str_q <= '0;
        end else begin
            if (accept) str_q <= stretch;
            if (active) held  <= held + 1'b1;
            else        held  <= '0;
        end
    end

    // R4: the strobe never ends before the programmed width has elapsed.
    p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (held >= HELD_W'(str_q)));
    // R5: ready low holds the strobe once the width is used up.
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (cnt == '0) && !rdy) |=> active);
    // R6: completion is one cycle long and directly follows a strobe.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(active));
endmodule

// File: rtl/xmem_access_ctrl.sv
// Module: top of the external data memory access controller. Registers
// the address and write data at acceptance, drives the strobes, data-bus
// tri-state control and captured read data.
// Assumes: the CPU holds off a new request until done; memory data is
// valid in the last strobe cycle (the cycle in which ready is high).
module xmem_access_ctrl #(
    parameter int PTR_W  = 16,
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8,
    parameter int DATA_W = 8,
    parameter int STR_W  = 3,
    localparam int ADDR_W = PTR_W + PAGE_W,
    localparam int HI_W   = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_mode,
    input  logic [STR_W-1:0]  stretch,
    input  logic [PTR_W-1:0]  dptr,
    input  logic [PAGE_W-1:0] page,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dz,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_rdy
);
    logic [ADDR_W-1:0] addr_next;
    logic              accept, active, last;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] dout_q, rdata_q;

    xmem_addr_gen #(
        .PTR_W (PTR_W),
        .PAGE_W(PAGE_W),
        .OFS_W (OFS_W)
    ) u_addr (
        .mode(req_mode),
        .ptr (dptr),
        .page(page),
        .hi  (hi_addr),
        .ofs (ofs),
        .addr(addr_next)
    );

    xmem_strobe_seq #(
        .STR_W(STR_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .stretch(stretch),
        .rdy    (mem_rdy),
        .accept (accept),
        .active (active),
        .last   (last),
        .done   (done)
    );

    // Latch address, write data and direction when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dout_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= addr_next;
            dout_q <= wdata;
            wr_q   <= req_wr;
        end
    end

    // Capture read data in the closing strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              rdata_q <= '0;
        else if (last && !wr_q)  rdata_q <= mem_din;
    end

    assign mem_addr = addr_q;
    assign mem_dout = dout_q;
    assign mem_rd   = active && !wr_q;
    assign mem_wr   = active && wr_q;
    assign mem_dz   = !(active && wr_q);
    assign rdata    = rdata_q;

    // R8: address and write data hold for the whole strobe.
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> ($stable(mem_addr) && $stable(mem_dout)));
    // R7: the data bus drives whenever the write strobe is high.
    p_dz_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_dz);
    // R10: the two strobes are exclusive.
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr}) <= 1);
    // R9: the direction of a running access cannot change mid-strobe.
    p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_wr) && (mem_rd || mem_wr)) |-> mem_wr);
endmodule

// File: tb/test_xmem_access_ctrl.sv
module test_xmem_access_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0, req_mode = 1'b0;
    logic [2:0]  stretch = '0;
    logic [15:0] dptr = '0, hi_addr = '0;
    logic [7:0]  page = '0, ofs = '0, wdata = '0;
    logic        done, mem_dz, mem_rd, mem_wr, mem_rdy;
    logic [7:0]  rdata, mem_dout, mem_din;
    logic [23:0] mem_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int dly_cfg = 0;
    int scnt = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_access_ctrl i_xmem_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_mode(req_mode),
        .stretch(stretch), .dptr(dptr), .page(page), .hi_addr(hi_addr), .ofs(ofs),
        .wdata(wdata), .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dz(mem_dz), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdy(mem_rdy)
    );

    function automatic logic [7:0] mem_model(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // Memory model: ready low for the first dly_cfg strobe cycles; data from address.
    always @(posedge clk) scnt <= (mem_rd || mem_wr) ? scnt + 1 : 0;
    assign mem_rdy = (scnt >= dly_cfg);
    assign mem_din = mem_model(mem_addr);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic access(input bit wr, input bit md, input int st, input int d,
                          input logic [15:0] p16, input logic [7:0] pg,
                          input logic [15:0] h16, input logic [7:0] o8,
                          input logic [7:0] wd, input bit inject);
        logic [23:0] exp_a;
        int n, exp_n;
        bit a_ok, dz_ok, do_ok, dir_ok;
        exp_a = md ? {h16, o8} : {pg, p16};
        exp_n = (st + 1 > d + 1) ? st + 1 : d + 1;
        a_ok = 1; dz_ok = 1; do_ok = 1; dir_ok = 1;
        @(negedge clk);
        dly_cfg = d;
        req_wr = wr; req_mode = md; stretch = 3'(st);
        dptr = p16; page = pg; hi_addr = h16; ofs = o8; wdata = wd;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while ((mem_rd || mem_wr) && n < 64) begin
            n++;
            if (mem_addr !== exp_a) a_ok = 0;
            if (mem_dz !== !wr) dz_ok = 0;
            if (wr && mem_dout !== wd) do_ok = 0;
            if (mem_wr !== wr || mem_rd !== !wr) dir_ok = 0;
            if (inject && n == 1) begin
                req = 1'b1; req_wr = !wr; req_mode = !md;
                dptr = ~p16; page = ~pg; hi_addr = ~h16; ofs = ~o8; wdata = ~wd;
            end
            @(negedge clk);
        end
        req = 1'b0;
        chk(n == exp_n, wr ? "R4/R5 write strobe width" : "R4/R5 read strobe width", n, exp_n);
        chk(a_ok, md ? "R3/R8 indirect address" : "R2/R8 pointer address", mem_addr, exp_a);
        chk(dz_ok, "R7 tri-state control during strobe", mem_dz, !wr);
        chk(dir_ok, "R10 strobe selection", {mem_rd, mem_wr}, {!wr, wr});
        if (wr) chk(do_ok, "R7/R8 write data on bus", mem_dout, wd);
        chk(done === 1'b1, "R6 done after strobe", done, 1);
        chk(mem_dz === 1'b1, "R7 bus released after strobe", mem_dz, 1);
        if (!wr) chk(rdata === mem_model(exp_a), "R6 read data", rdata, mem_model(exp_a));
        @(negedge clk);
        chk(done === 1'b0, "R6 done is one cycle", done, 0);
        if (inject) begin
            bit quiet;
            quiet = 1;
            for (int k = 0; k < 4; k++) begin
                if (mem_rd || mem_wr || done) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, "R9 request during access ignored", {mem_rd, mem_wr, done}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R1 strobes low in reset", {mem_rd, mem_wr}, 0);
        chk(done === 1'b0, "R1 done low in reset", done, 0);
        chk(mem_dz === 1'b1, "R1 bus released in reset", mem_dz, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_rd === 1'b0 && mem_wr === 1'b0 && mem_dz === 1'b1, "R1 idle after reset",
            {mem_rd, mem_wr, mem_dz}, 1);
        for (int st = 0; st < 8; st++)
            for (int d = 0; d < 10; d++)
                for (int w = 0; w < 2; w++)
                    for (int m = 0; m < 2; m++)
                        access(w[0], m[0], st, d,
                               16'(st * 4099 + d * 257 + w * 31 + m * 7),
                               8'(d * 17 + m + st * 3),
                               16'(st * 613 + d * 11 + w),
                               8'(st * 29 + d * 3 + w),
                               8'(st * 37 + d * 5 + m * 64 + w),
                               ((st + d + w) % 3) == 0);
        // Corner values on the address fields.
        access(1'b0, 1'b0, 0, 0, 16'hFFFF, 8'hFF, 16'h0000, 8'h00, 8'h00, 1'b1);
        access(1'b1, 1'b1, 7, 0, 16'h0000, 8'h00, 16'hFFFF, 8'hFF, 8'hFF, 1'b1);
        access(1'b0, 1'b1, 0, 12, 16'h1234, 8'h56, 16'h8001, 8'h80, 8'h3C, 1'b0);
        summary();
        $finish;
    end
endmodule